// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Cell

This block is one programmable cell of a sum-of-products logic fabric. A static configuration word sets its behaviour. The cell takes 36 signals from the global routing and 16 shared expander terms, and it can combine any of them, true or inverted, into five product terms. A per-term route field sends each term to one of three places: the OR gate that feeds a polarity XOR, a control input of the cell register (clear, preset, clock or enable), or the second data input used by the JK and SR modes.

The cell register can act as a D, T, JK or SR storage element, or it can be bypassed so that the XOR result goes straight to the outputs. The register is clocked by whichever of three sources the configuration picks: one of two global clocks, or a clock formed from product terms. The design detects a rising edge of that source on the system clock `clk`. A fast path lets the register load from the cell's pad input instead of the logic sum. The same registered result drives both the pin path and the global routing feedback.

Clear and preset do not depend on the cell clock or the enable. Whenever either is asserted it acts at the next system clock, and clear wins when both are asserted.

Top module: `mc_macrocell`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the cell register, the clock-edge history and both outputs are cleared to 0.
- R2: Literal k is `pia_in[k]` for k below 36 and `exp_in[k-36]` for k from 36 to 51. Term t reads its true-literal mask from `cfg[104t+51:104t]` and its inverted-literal mask from `cfg[104t+103:104t+52]`. Each term is the AND of all selected literals. A term with no literal selected is 1. A term that selects one literal in both polarities is 0.
- R3: The route code of term t sits at `cfg[520+3t+2:520+3t]`: 0 sum, 1 clear, 2 preset, 3 clock, 4 enable, 5 second data input; codes 6 and 7 leave the term unused. The sum value is the OR of the terms with code 0, XORed with the polarity bit `cfg[535]`. When the bypass bit `cfg[538]` is 1, the outputs show this value one `clk` cycle later.
- R4: Mode bits `cfg[537:536]` set to 0 select D mode. The register loads its data input only at a `clk` edge where the selected clock source is high and was low at the previous edge, and the enable is high. The outputs show the register one cycle after it changes, when bypass is 0.
- R5: Clock select `cfg[540:539]`: 0 picks `gclk[0]`, 1 picks `gclk[1]`, 2 or 3 picks the OR of the terms with route code 3.
- R6: The enable is the OR of the terms with route code 4. When no term has code 4, the enable is always 1.
- R7: Mode 1 (T): on a qualified edge the register inverts when its data input is 1 and holds otherwise.
- R8: Mode 2 (JK): J is the data input and K is the OR of the terms with route code 5. The four cases are: 00 hold, 01 clear, 10 set, 11 toggle.
- R9: Mode 3 (SR): S is the data input and R is the OR of the code-5 terms. The four cases are: 00 hold, 01 clear, 10 set, 11 hold.
- R10: Clear source bit `cfg[541]`: 0 uses `!gclr_n`, 1 uses the OR of the code-1 terms. Preset is the OR of the code-2 terms. Clear or preset forces the register at the next `clk` edge regardless of the cell clock and enable, and clear takes priority.
- R11: When the fast-input bit `cfg[542]` is 1, the register data input is `fast_in` instead of the sum value. The bypass output still shows the sum value.
- R12: `pin_out` and `gbl_out` always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg | input | 543 | Static configuration word |
| pia_in | input | 36 | Signals from the global routing |
| exp_in | input | 16 | Shared expander terms |
| fast_in | input | 1 | Direct input from the cell's pad |
| gclk | input | 2 | Global clock signals, sampled on `clk` |
| gclr_n | input | 1 | Global clear, active low |
| pin_out | output | 1 | Registered result to the pin path |
| gbl_out | output | 1 | Registered result to the global routing |

## Verification
The bench looks for these corner cases:

- **Product-term edges.** It checks an empty term, which must read 1, and a term that selects one literal in both polarities, which must read 0. A mask decoder that ignores the inverted half, or that treats an empty term as 0, makes the bypass output wrong.
- **Clock qualification.** It drives levels that are held high across several edges, and it checks the enable both unrouted and routed. A design that loads on a level instead of a rising edge, or that disables the cell when no term is routed to the enable, shows a wrong register value.
- **Clear, preset and the two-input modes.** Clear and preset arrive together and without any clock edge, and the JK and SR modes receive both inputs at 1. A cell that favours preset, that waits for a clock edge, or that toggles in SR mode diverges from the model within a few cycles.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [2:0] {
    RT_SUM  = 3'd0,
    RT_CLR  = 3'd1,
    RT_PRE  = 3'd2,
    RT_CLK  = 3'd3,
    RT_ENA  = 3'd4,
    RT_AUX  = 3'd5,
    RT_OFFA = 3'd6,
    RT_OFFB = 3'd7
  } route_e;

  typedef enum logic [1:0] {
    FF_D  = 2'd0,
    FF_T  = 2'd1,
    FF_JK = 2'd2,
    FF_SR = 2'd3
  } ffmode_e;

  typedef enum logic [1:0] {
    CK_G0  = 2'd0,
    CK_G1  = 2'd1,
    CK_PT  = 2'd2,
    CK_PT2 = 2'd3
  } clksel_e;

  // Steered control values produced by the select matrix
  typedef struct packed {
    logic sum;
    logic clr;
    logic pre;
    logic clk;
    logic ena;
    logic aux;
  } ctl_s;

endpackage

// File: rtl/mc_term_array.sv
module mc_term_array #(
  parameter int N_LIT   = 52,
  parameter int N_TERMS = 5
) (
  input  logic [N_LIT-1:0]         lit,
  input  logic [N_TERMS*N_LIT-1:0] true_mask,
  input  logic [N_TERMS*N_LIT-1:0] inv_mask,
  output logic [N_TERMS-1:0]       term
);

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    logic [N_LIT-1:0] tm;
    logic [N_LIT-1:0] im;
    assign tm = true_mask[t*N_LIT +: N_LIT];
    assign im = inv_mask[t*N_LIT +: N_LIT];
    // unselected literals read as 1 so they drop out of the AND
    assign term[t] = (&(~tm | lit)) & (&(~im | ~lit));
  end

endmodule

// File: rtl/mc_select_matrix.sv
module mc_select_matrix
  import mc_pkg::*;
#(
  parameter int N_TERMS = 5
) (
  input  logic [N_TERMS-1:0]   term,
  input  logic [3*N_TERMS-1:0] route,
  output ctl_s                 ctl
);

  logic ena_any;
  logic ena_or;

  always_comb begin
    ctl     = '0;
    ena_any = 1'b0;
    ena_or  = 1'b0;
    for (int t = 0; t < N_TERMS; t++) begin
      case (route_e'(route[3*t +: 3]))
        RT_SUM: ctl.sum = ctl.sum | term[t];
        RT_CLR: ctl.clr = ctl.clr | term[t];
        RT_PRE: ctl.pre = ctl.pre | term[t];
        RT_CLK: ctl.clk = ctl.clk | term[t];
        RT_ENA: begin
          ena_any = 1'b1;
          ena_or  = ena_or | term[t];
        end
        RT_AUX: ctl.aux = ctl.aux | term[t];
        default: ;
      endcase
    end
    // an enable with no term routed to it stays active
    ctl.ena = ena_any ? ena_or : 1'b1;
  end

endmodule

// File: rtl/mc_flop.sv
module mc_flop
  import mc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  ffmode_e mode,
  input  logic    d,
  input  logic    aux,
  input  logic    src,
  input  logic    ena,
  input  logic    clr,
  input  logic    pre,
  output logic    q
);

  logic prev;
  logic fire;
  logic nxt;

  assign fire = src & ~prev & ena;

  always_comb begin
    nxt = q;
    case (mode)
      FF_D:  nxt = d;
      FF_T:  nxt = q ^ d;
      FF_JK: case ({d, aux})
               2'b01:   nxt = 1'b0;
               2'b10:   nxt = 1'b1;
               2'b11:   nxt = ~q;
               default: nxt = q;
             endcase
      FF_SR: case ({d, aux})
               2'b01:   nxt = 1'b0;
               2'b10:   nxt = 1'b1;
               default: nxt = q;
             endcase
      default: nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= 1'b0;
      prev <= 1'b0;
    end else begin
      prev <= src;
      if (clr)       q <= 1'b0;
      else if (pre)  q <= 1'b1;
      else if (fire) q <= nxt;
    end
  end

  assert_clr_wins_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == 1'b0));
  assert_pre_sets_R10: assert property (@(posedge clk) disable iff (rst)
    (pre && !clr) |=> q);
  assert_hold_no_edge_R4: assert property (@(posedge clk) disable iff (rst)
    (!clr && !pre && !fire) |=> $stable(q));
  assert_d_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == FF_D && fire && !clr && !pre) |=> (q == $past(d)));
  assert_t_toggle_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == FF_T && fire && d && !clr && !pre) |=> (q != $past(q)));

endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
  import mc_pkg::*;
#(
  parameter  int N_ROUTED   = 36,
  parameter  int N_EXPAND   = 16,
  parameter  int N_TERMS    = 5,
  localparam int N_LIT      = N_ROUTED + N_EXPAND,
  localparam int TERM_BITS  = 2 * N_LIT,
  localparam int ROUTE_BASE = N_TERMS * TERM_BITS,
  localparam int MISC_BASE  = ROUTE_BASE + 3 * N_TERMS,
  localparam int CFG_W      = MISC_BASE + 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  cfg,
  input  logic [N_ROUTED-1:0] pia_in,
  input  logic [N_EXPAND-1:0] exp_in,
  input  logic              fast_in,
  input  logic [1:0]        gclk,
  input  logic              gclr_n,
  output logic              pin_out,
  output logic              gbl_out
);

  localparam int POL_BIT    = MISC_BASE;
  localparam int MODE_LSB   = MISC_BASE + 1;
  localparam int BYP_BIT    = MISC_BASE + 3;
  localparam int CKSEL_LSB  = MISC_BASE + 4;
  localparam int CLRSEL_BIT = MISC_BASE + 6;
  localparam int FAST_BIT   = MISC_BASE + 7;

  logic [N_LIT-1:0]         lit;
  logic [N_TERMS*N_LIT-1:0] true_mask;
  logic [N_TERMS*N_LIT-1:0] inv_mask;
  logic [N_TERMS-1:0]       term;
  ctl_s                     ctl;
  logic                     comb_val;
  logic                     d_in;
  logic                     clk_src;
  logic                     clr_act;
  logic                     q;
  logic                     out_r;
  clksel_e                  cksel;

  assign lit = {exp_in, pia_in};

  for (genvar t = 0; t < N_TERMS; t++) begin : g_mask
    assign true_mask[t*N_LIT +: N_LIT] = cfg[t*TERM_BITS +: N_LIT];
    assign inv_mask[t*N_LIT +: N_LIT]  = cfg[t*TERM_BITS + N_LIT +: N_LIT];
  end

  mc_term_array #(.N_LIT(N_LIT), .N_TERMS(N_TERMS)) u_terms (
    .lit       (lit),
    .true_mask (true_mask),
    .inv_mask  (inv_mask),
    .term      (term)
  );

  mc_select_matrix #(.N_TERMS(N_TERMS)) u_sel (
    .term  (term),
    .route (cfg[ROUTE_BASE +: 3*N_TERMS]),
    .ctl   (ctl)
  );

  assign comb_val = ctl.sum ^ cfg[POL_BIT];
  assign d_in     = cfg[FAST_BIT] ? fast_in : comb_val;
  assign cksel    = clksel_e'(cfg[CKSEL_LSB +: 2]);
  assign clr_act  = cfg[CLRSEL_BIT] ? ctl.clr : ~gclr_n;

  always_comb begin
    case (cksel)
      CK_G0:   clk_src = gclk[0];
      CK_G1:   clk_src = gclk[1];
      default: clk_src = ctl.clk;
    endcase
  end

  mc_flop u_ff (
    .clk  (clk),
    .rst  (rst),
    .mode (ffmode_e'(cfg[MODE_LSB +: 2])),
    .d    (d_in),
    .aux  (ctl.aux),
    .src  (clk_src),
    .ena  (ctl.ena),
    .clr  (clr_act),
    .pre  (ctl.pre),
    .q    (q)
  );

  always_ff @(posedge clk) begin
    if (rst) out_r <= 1'b0;
    else     out_r <= cfg[BYP_BIT] ? comb_val : q;
  end

  assign pin_out = out_r;
  assign gbl_out = out_r;

endmodule

// File: tb/sim_mc_macrocell.sv
module sim_mc_macrocell;

  localparam int L  = 52;
  localparam int RB = 520;
  localparam int MB = 535;
  localparam int CW = 543;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] cfg = '0;
  logic [35:0]   pia_in = '0;
  logic [15:0]   exp_in = '0;
  logic          fast_in = 1'b0;
  logic [1:0]    gclk = 2'b00;
  logic          gclr_n = 1'b1;
  logic          pin_out;
  logic          gbl_out;

  int    nchk = 0;
  int    nbad = 0;
  bit    done = 0;
  bit    rnd_gclr = 0;
  string req = "R1";

  logic m_q = 0, m_prev = 0, m_out = 0;

  always #4 clk = ~clk;

  mc_macrocell u0 (
    .clk(clk), .rst(rst), .cfg(cfg), .pia_in(pia_in), .exp_in(exp_in),
    .fast_in(fast_in), .gclk(gclk), .gclr_n(gclr_n),
    .pin_out(pin_out), .gbl_out(gbl_out)
  );

  task automatic cfg_blank();
    cfg = '0;
    for (int t = 0; t < 5; t++) cfg[RB+3*t +: 3] = 3'd6;
  endtask

  task automatic use_lit(int t, int k, bit inverted);
    cfg[t*2*L + (inverted ? L : 0) + k] = 1'b1;
  endtask

  task automatic route(int t, int code);
    cfg[RB+3*t +: 3] = code[2:0];
  endtask

  task automatic misc(bit pol, int mode, bit byp, int cks, bit clrsel, bit fast);
    cfg[MB] = pol;
    cfg[MB+1 +: 2] = mode[1:0];
    cfg[MB+3] = byp;
    cfg[MB+4 +: 2] = cks[1:0];
    cfg[MB+6] = clrsel;
    cfg[MB+7] = fast;
  endtask

  task automatic check(bit cond, string what, logic act, logic exp);
    nchk++;
    if (!cond) begin
      nbad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // one system clock with a behavioural model of the next state
  task automatic tick();
    logic [51:0] lit;
    logic tv, sum, cclr, cpre, cclk, eor, eany, aux, comb, d, src, clr, ena, fire, nq, n_out;
    lit = {exp_in, pia_in};
    sum = 0; cclr = 0; cpre = 0; cclk = 0; eor = 0; eany = 0; aux = 0;
    for (int t = 0; t < 5; t++) begin
      tv = 1;
      for (int k = 0; k < L; k++) begin
        if (cfg[t*2*L + k] && !lit[k]) tv = 0;
        if (cfg[t*2*L + L + k] && lit[k]) tv = 0;
      end
      case (cfg[RB+3*t +: 3])
        3'd0: sum  = sum  | tv;
        3'd1: cclr = cclr | tv;
        3'd2: cpre = cpre | tv;
        3'd3: cclk = cclk | tv;
        3'd4: begin eany = 1; eor = eor | tv; end
        3'd5: aux  = aux  | tv;
        default: ;
      endcase
    end
    comb = sum ^ cfg[MB];
    d    = cfg[MB+7] ? fast_in : comb;
    src  = (cfg[MB+4 +: 2] == 0) ? gclk[0] : (cfg[MB+4 +: 2] == 1) ? gclk[1] : cclk;
    clr  = cfg[MB+6] ? cclr : !gclr_n;
    ena  = eany ? eor : 1'b1;
    fire = src && !m_prev && ena;
    nq = m_q;
    if (clr) nq = 0;
    else if (cpre) nq = 1;
    else if (fire) begin
      case (cfg[MB+1 +: 2])
        2'd0: nq = d;
        2'd1: nq = m_q ^ d;
        2'd2: nq = (d && aux) ? !m_q : d ? 1'b1 : aux ? 1'b0 : m_q;
        default: nq = (d && !aux) ? 1'b1 : (!d && aux) ? 1'b0 : m_q;
      endcase
    end
    n_out = cfg[MB+3] ? comb : m_q;
    @(posedge clk);
    @(negedge clk);
    if (rst) begin m_q = 0; m_prev = 0; m_out = 0; end
    else begin m_q = nq; m_prev = src; m_out = n_out; end
    check(pin_out === m_out, "pin_out", pin_out, m_out);
    check(gbl_out === m_out, "gbl_out (R12)", gbl_out, m_out);
  endtask

  task automatic do_reset();
    rst = 1;
    tick();
    tick();
    rst = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      pia_in  = {$urandom, $urandom};
      exp_in  = 16'($urandom);
      fast_in = 1'($urandom);
      gclk    = 2'($urandom);
      gclr_n  = rnd_gclr ? (($urandom % 4) != 0) : 1'b1;
      tick();
    end
  endtask

  initial begin
    // R1: reset clears outputs
    req = "R1";
    cfg_blank(); misc(1, 0, 1, 0, 0, 0); route(0, 0);
    do_reset();
    check(pin_out === 1'b0, "reset pin_out R1", pin_out, 1'b0);
    check(gbl_out === 1'b0, "reset gbl_out R1", gbl_out, 1'b0);

    // R2 / R3: bypass sum with mixed polarities, contradictory term, polarity bit
    req = "R2";
    cfg_blank(); use_lit(0, 0, 0); use_lit(0, 36, 1); route(0, 0);
    use_lit(1, 5, 0); use_lit(1, 5, 1); route(1, 0);
    misc(0, 0, 1, 0, 0, 0); do_reset(); run(40);
    req = "R3";
    misc(1, 0, 1, 0, 0, 0); run(40);
    // R2: empty term reads 1, unused route codes 6/7 are ignored
    req = "R2";
    cfg_blank(); route(2, 0); use_lit(3, 7, 0); route(3, 7);
    misc(0, 0, 1, 0, 0, 0); do_reset(); run(20);

    // R4: D mode on global clock 0
    req = "R4";
    cfg_blank(); use_lit(0, 1, 0); route(0, 0);
    misc(0, 0, 0, 0, 0, 0); do_reset(); run(60);
    // R5: global clock 1, then product-term clock
    req = "R5";
    misc(0, 0, 0, 1, 0, 0); do_reset(); run(60);
    use_lit(3, 2, 0); route(3, 3);
    misc(0, 0, 0, 2, 0, 0); do_reset(); run(60);
    // R6: enable from a product term
    req = "R6";
    use_lit(4, 3, 0); route(4, 4); do_reset(); run(60);

    // R7: T mode
    req = "R7";
    cfg_blank(); use_lit(0, 1, 0); route(0, 0);
    misc(0, 1, 0, 0, 0, 0); do_reset(); run(60);
    // R8: JK mode, K from code-5 term
    req = "R8";
    use_lit(1, 4, 0); route(1, 5);
    misc(0, 2, 0, 0, 0, 0); do_reset(); run(80);
    // R9: SR mode, S=R=1 holds
    req = "R9";
    misc(0, 3, 0, 0, 0, 0); do_reset(); run(80);

    // R10: global clear, then product-term clear against preset
    req = "R10";
    cfg_blank(); use_lit(0, 1, 0); route(0, 0);
    misc(0, 0, 0, 0, 0, 0); rnd_gclr = 1; do_reset(); run(60);
    rnd_gclr = 0;
    use_lit(2, 5, 0); route(2, 1); use_lit(3, 6, 0); route(3, 2);
    misc(0, 0, 0, 0, 1, 0); do_reset(); run(80);

    // R11: fast input to register, then bypass still shows the sum
    req = "R11";
    cfg_blank(); use_lit(0, 1, 0); route(0, 0);
    misc(0, 0, 0, 0, 0, 1); do_reset(); run(60);
    misc(0, 0, 1, 0, 0, 1); do_reset(); run(30);

    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog %s: actual=hung expected=finished", req);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

endmodule